// File: doc/BRIEF.md
# Heartbeat Watchdog with Low-Supply Override

This block watches a heartbeat line that a processor toggles from its main loop. Each change of level on that line, whether rising or falling, restarts a timeout count of `TIMEOUT_CYCLES` clock cycles. If the count runs out with no change, an active-low timeout output goes low. The output is meant for a non-maskable interrupt. It can also be wired back to a reset input, so that a stalled processor gets a full restart.

A supply-good indication, produced by an analog comparator elsewhere, takes priority over the timer. While it reports low supply, the timeout output is held low. This holds whatever the timer state, the enable and the reset. A synchronous enable stands in for a heartbeat line that is left unconnected. With the enable low, the timer is parked at zero and the output becomes a pure low-supply flag.

The heartbeat and the supply indication are asynchronous to `clk`. Each passes through a two-flop synchroniser. The output is registered. A synchronous active-high reset holds the timer clear, so timing starts only once reset is released.

Top module: `hb_watchdog`

## Requirements
- R1: With `supply_ok` high and no timeout pending, `wdt_n` is high, including throughout reset. It stays high while the heartbeat changes level at least once every `TIMEOUT_CYCLES` cycles. A change first sampled at rising edge E keeps `wdt_n` high when the next change is first sampled no later than edge E+`TIMEOUT_CYCLES`.
- R2: With `wd_en` high, `rst` low and `supply_ok` high, suppose `hb_in` changes level and is first sampled at rising edge E, and then makes no further change. `wdt_n` goes low after edge E+`TIMEOUT_CYCLES`+3 and is still high after edge E+`TIMEOUT_CYCLES`+2.
- R3: A rising transition and a falling transition of `hb_in` each restart the count with the same timing.
- R4: While `rst` is high, the count and the timeout condition are cleared. If E is the first rising edge with `rst` low and `hb_in` is steady, `wdt_n` goes low after edge E+`TIMEOUT_CYCLES`. It is high after edge E+`TIMEOUT_CYCLES`-1.
- R5: If `supply_ok` goes low at rising edge E, `wdt_n` is low after edge E+2, one edge after it would otherwise change. It stays low for as long as `supply_ok` stays low, regardless of `rst`, `wd_en` or heartbeat activity. When `supply_ok` returns high at E with no timeout pending, `wdt_n` is high after edge E+2.
- R6: While `wd_en` is sampled low, the count is held at zero and the timeout condition is cleared. `wdt_n` then follows only `supply_ok`. A timeout that is pending when `wd_en` is first sampled low at edge E releases `wdt_n` after edge E+1. With `wd_en` sampled high again from edge E, timing restarts as in R4.
- R7: Once timed out, `wdt_n` stays low until a heartbeat change or a reset. A change first sampled at edge E sets `wdt_n` high after edge E+3 and restarts the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears the timer |
| hb_in | input | 1 | Asynchronous heartbeat line; any level change restarts the count |
| wd_en | input | 1 | Synchronous heartbeat-monitor enable; low parks the timer |
| supply_ok | input | 1 | Asynchronous supply-good indication, high when supply is adequate |
| wdt_n | output | 1 | Registered active-low output: timeout or low supply |

## Verification
The heartbeat is driven with regular toggling at the longest legal spacing and with a single final change followed by silence. The first pattern shows whether a change landing exactly on the deadline still keeps the output high. The second fixes the exact cycle at which the output falls after a rising change and after a falling change. Low-supply pulses are placed during counting, during a pending timeout, under disable and under reset, which separates the override path from the timer path. Disable and reset pulses are placed both while counting and after expiry, which shows that each clears a pending timeout and restarts timing from zero.

// File: rtl/hb_wd_pkg.sv
package hb_wd_pkg;

  localparam int SYNC_DEPTH = 2;

  function automatic int cnt_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int STAGES = hb_wd_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) sr[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk) sr[i] <= sr[i-1];
      end
    end
  endgenerate

  assign q = sr[STAGES-1];

endmodule

// File: rtl/hb_edge_detect.sv
module hb_edge_detect #(
  parameter int STAGES = hb_wd_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic hb_raw,
  output logic hb_edge
);

  logic hb_s;
  logic hb_d;

  hb_sync #(.STAGES(STAGES)) u_sync (
    .clk (clk),
    .d   (hb_raw),
    .q   (hb_s)
  );

  always_ff @(posedge clk) hb_d <= hb_s;

  assign hb_edge = hb_s ^ hb_d;

endmodule

// File: rtl/hb_timeout_counter.sv
module hb_timeout_counter #(
  parameter int TIMEOUT_CYCLES = 80_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic hb_edge,
  output logic expired
);

  localparam int CNT_W = hb_wd_pkg::cnt_bits(TIMEOUT_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !enable || hb_edge) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (cnt == LAST) begin
      expired <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R2

  AST_EDGE_RESTART: assert property (@(posedge clk) disable iff (rst)
    (hb_edge && enable) |=> (cnt == '0 && !expired)); // R3

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (cnt == '0 && !expired)); // R4

  AST_DISABLE_PARK: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (cnt == '0 && !expired)); // R6

  AST_EXPIRED_STICKY: assert property (@(posedge clk) disable iff (rst)
    (expired && enable && !hb_edge) |=> expired); // R7

endmodule

// File: rtl/hb_out_stage.sv
module hb_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic supply_good,
  input  logic expired,
  output logic out_n
);

  always_ff @(posedge clk) begin
    if (rst) out_n <= supply_good;
    else     out_n <= supply_good & ~expired;
  end

  AST_SUPPLY_FORCE: assert property (@(posedge clk) disable iff (rst)
    !supply_good |=> !out_n); // R5

  AST_TIMEOUT_LOW: assert property (@(posedge clk) disable iff (rst)
    expired |=> !out_n); // R2

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (supply_good && !expired) |=> out_n); // R1

endmodule

// File: rtl/hb_watchdog.sv
module hb_watchdog #(
  parameter int TIMEOUT_CYCLES = 80_000_000,
  parameter int SYNC_STAGES    = hb_wd_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst,
  input  logic hb_in,
  input  logic wd_en,
  input  logic supply_ok,
  output logic wdt_n
);

  logic hb_edge;
  logic supply_s;
  logic expired;

  hb_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .hb_raw  (hb_in),
    .hb_edge (hb_edge)
  );

  hb_sync #(.STAGES(SYNC_STAGES)) u_supply_sync (
    .clk (clk),
    .d   (supply_ok),
    .q   (supply_s)
  );

  hb_timeout_counter #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_counter (
    .clk     (clk),
    .rst     (rst),
    .enable  (wd_en),
    .hb_edge (hb_edge),
    .expired (expired)
  );

  hb_out_stage u_out (
    .clk         (clk),
    .rst         (rst),
    .supply_good (supply_s),
    .expired     (expired),
    .out_n       (wdt_n)
  );

endmodule

// File: tb/hb_watchdog_bench.sv
module hb_watchdog_bench;

  localparam int T = 20;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, hb = 1'b0, wd_en = 1'b1, supply_ok = 1'b1;
  logic wdt_n;

  int  n_chk = 0, n_fail = 0;
  bit  cmp_on = 0, done = 0;

  bit  hbq[$];
  bit  supq[$];
  int  m_cnt = 0;
  bit  m_flag = 0;
  bit  m_out = 1;

  hb_watchdog #(.TIMEOUT_CYCLES(T)) u_hb_watchdog (
    .clk       (clk),
    .rst       (rst),
    .hb_in     (hb),
    .wd_en     (wd_en),
    .supply_ok (supply_ok),
    .wdt_n     (wdt_n)
  );

  initial begin
    repeat (4) hbq.push_front(1'b0);
    repeat (3) supq.push_front(1'b0);
  end

  // Behavioural reference: queued input history, integer count.
  always @(posedge clk) begin : model
    bit e, s, nout;
    hbq.push_front(hb);
    if (hbq.size() > 4) void'(hbq.pop_back());
    supq.push_front(supply_ok);
    if (supq.size() > 3) void'(supq.pop_back());
    e = (hbq[2] != hbq[3]);
    s = supq[2];
    nout = rst ? s : (s && !m_flag);
    if (rst || !wd_en || e) begin
      m_cnt = 0;
      m_flag = 0;
    end else if (m_cnt == T - 1) begin
      m_flag = 1;
    end else begin
      m_cnt++;
    end
    m_out = nout;
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      string tag;
      tag = rst ? "R4" : (!wd_en ? "R6" : (!supply_ok ? "R5" : "R2"));
      n_chk++;
      if (wdt_n !== m_out) begin
        n_fail++;
        $display("FAIL %s model compare: wdt_n=%0b expected %0b", tag, wdt_n, m_out);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: wdt_n=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL R1 watchdog expired: finished=0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wait_n(5);
    chk("R1 reset state", wdt_n, 1'b1);
    cmp_on = 1;

    // R4: timing starts at reset release, steady heartbeat
    rst = 1'b0;
    wait_n(T);
    chk("R4 before deadline", wdt_n, 1'b1);
    wait_n(1);
    chk("R4 deadline after release", wdt_n, 1'b0);

    // R7: stays low, rising change releases it after E+3
    wait_n(10);
    chk("R7 sticky low", wdt_n, 1'b0);
    hb = 1'b1;
    wait_n(3);
    chk("R7 still low before release", wdt_n, 1'b0);
    wait_n(1);
    chk("R7 released by edge", wdt_n, 1'b1);

    // R1/R3: toggling at the longest legal spacing keeps output high
    for (int i = 0; i < 6; i++) begin
      hb = ~hb;
      wait_n(T);
      chk("R1 R3 spacing at limit", wdt_n, 1'b1);
    end

    // R2 with a falling final change
    hb = 1'b0;
    wait_n(T + 3);
    chk("R2 falling, one before deadline", wdt_n, 1'b1);
    wait_n(1);
    chk("R2 falling, deadline", wdt_n, 1'b0);

    // R3 rising change: release, then same deadline
    hb = 1'b1;
    wait_n(4);
    chk("R3 rising release", wdt_n, 1'b1);
    wait_n(T - 1);
    chk("R3 rising, one before deadline", wdt_n, 1'b1);
    wait_n(1);
    chk("R3 rising, deadline", wdt_n, 1'b0);

    // R5: supply override
    hb = 1'b0;
    wait_n(4);
    chk("R7 release before supply test", wdt_n, 1'b1);
    supply_ok = 1'b0;
    wait_n(2);
    chk("R5 latency, not yet low", wdt_n, 1'b1);
    wait_n(1);
    chk("R5 forced low", wdt_n, 1'b0);
    hb = 1'b1;
    wait_n(5);
    chk("R5 heartbeat cannot lift", wdt_n, 1'b0);
    wd_en = 1'b0;
    wait_n(5);
    chk("R5 low while disabled", wdt_n, 1'b0);
    rst = 1'b1;
    wait_n(5);
    chk("R5 low during reset", wdt_n, 1'b0);
    rst = 1'b0;
    supply_ok = 1'b1;
    wait_n(2);
    chk("R5 restore latency", wdt_n, 1'b0);
    wait_n(1);
    chk("R5 restored high", wdt_n, 1'b1);

    // R6: disabled mode
    wait_n(3 * T);
    chk("R6 no timeout while disabled", wdt_n, 1'b1);
    wd_en = 1'b1;
    wait_n(T);
    chk("R6 re-enable, before deadline", wdt_n, 1'b1);
    wait_n(1);
    chk("R6 re-enable deadline", wdt_n, 1'b0);
    wd_en = 1'b0;
    wait_n(1);
    chk("R6 disable latency", wdt_n, 1'b0);
    wait_n(1);
    chk("R6 disable clears timeout", wdt_n, 1'b1);

    // R4: reset in mid-timeout clears and restarts timing
    wd_en = 1'b1;
    wait_n(T + 1);
    chk("R4 timed out before reset", wdt_n, 1'b0);
    rst = 1'b1;
    wait_n(1);
    chk("R4 reset releases output", wdt_n, 1'b1);
    wait_n(3);
    rst = 1'b0;
    wait_n(T);
    chk("R4 restart, before deadline", wdt_n, 1'b1);
    wait_n(1);
    chk("R4 restart deadline", wdt_n, 1'b0);

    cmp_on = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule